// File: doc/BRIEF.md
# Three-Weight Accumulator Test Pattern Generator

This block produces one weighted pseudo-random test vector per clock for a combinational circuit under test. The datapath is a plain ripple-carry accumulator. Each bit is a full-adder cell feeding a pattern flip-flop (register A) and an addend flip-flop (register B), and both flip-flops have asynchronous set and clear. A weight is imposed on an input bit only by driving these set and clear pins. The adder itself is never changed.

A bit can be held at 1 (weight 1), held at 0 (weight 0), or left free (weight one half). A free bit takes the bits of the running sum A + B. The addend bits come from a maximal-length LFSR. A small constant table holds one weight assignment per session. A session counter walks through the table, and a pattern counter applies a fixed number of patterns under each assignment. A start pulse launches a run. Each update is followed by a valid strobe, and the run ends with a done flag that holds the last pattern.

Top module: `tw_pattern_gen`

## Requirements
- R1: While reset is asserted and just after it, the pattern is all zeros, and pat_valid_o and done_o are low.
- R2: Each session entry carries a 2-bit code per input in bits [2i+1:2i]. Code 00 leaves bit i free, 01 holds it at 1, 10 holds it at 0, and 11 is treated exactly like 00.
- R3: A held bit keeps its forced value for the whole session. After each update, every free bit equals the matching bit of (A + B) mod 2^WIDTH, where A and B are the values before the update, the carry into bit 0 is 0, and held bits take part in the sum with their forced A and B values.
- R4: Each free B bit i loads bit i of an LFSR at every update, and the LFSR then advances. For the default 8-bit width the LFSR shifts toward the MSB, and its new bit 0 is the XOR of bits 7, 5, 4 and 3. It starts from the nonzero constant SEED (default 0xA5) at reset and never becomes zero.
- R5: While running, the accumulator updates once per clock. pat_valid_o is high in the cycle after each update, and low in the cycle after the start is taken.
- R6: Exactly PATS_PER_SESSION patterns are applied under each assignment. Sessions are used in the order 0, 1, 2, 3, and the forcing of a session takes effect right after the clock edge that starts it.
- R7: The default table comes from intersecting the vector pairs (00101, 01010), (01010, 10010), (10010, 11111) and (00101, 11111), written MSB first. Equal 0s give weight 0, equal 1s give weight 1, and differing bits give a free bit. The resulting assignments are 0----, --010, 1--1- and --1-1.
- R8: done_o rises in the same cycle as the final valid strobe. After that, pat_valid_o stays low and the pattern stays unchanged until start_i is taken again.
- R9: start_i is ignored while a run is active. When start_i is taken after done, the generator returns to session 0 and clears done_o. The A, B and LFSR state carries on from where it stopped.
- R10: A weight-1 bit has A=1 and B=0, and a weight-0 bit has A=0 and B=1, through cross-wired set and clear lines. In either case the bit passes its carry-in unchanged to its carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a run of all sessions (taken only when idle) |
| pattern_o | output | WIDTH | Current test vector (register A) |
| pat_valid_o | output | 1 | High for one cycle after each accumulator update |
| done_o | output | 1 | High from the final pattern until the next start |

## Verification
The assertions check the cycle-level invariants on every cycle. Held bits are stable within a session, and the cell flip-flops hold the complementary A/B values under forcing. Held cells pass their carry through, sessions advance by exactly one, the LFSR stays nonzero, and the pattern stays frozen while done. Only the bench scenarios can show that the free bits follow the sum and LFSR sequence exactly, since that needs an independent arithmetic model. The same is true of the exact count of patterns per session and the table derived from the vector pairs. The bench scenarios also cover the handling of start during and after a run and the treatment of code 11, using a second instance with a custom table.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int NSESS = 4;
    localparam int MAX_W = 16;

    typedef logic [NSESS-1:0][2*MAX_W-1:0] wtab_t;

    typedef enum logic [1:0] {
        WC_FREE = 2'b00,
        WC_ONE  = 2'b01,
        WC_ZERO = 2'b10,
        WC_ILL  = 2'b11
    } wcode_e;

    // Weight table built from pairwise intersections of four seed vectors;
    // inputs wider than five reuse the seed bits cyclically.
    function automatic wtab_t default_wtab();
        logic [4:0] vec [4];
        int         pa  [4];
        int         pb  [4];
        wtab_t      t;
        logic       x;
        logic       y;
        vec[0] = 5'b00101; vec[1] = 5'b01010; vec[2] = 5'b10010; vec[3] = 5'b11111;
        pa[0] = 0; pb[0] = 1;
        pa[1] = 1; pb[1] = 2;
        pa[2] = 2; pb[2] = 3;
        pa[3] = 0; pb[3] = 3;
        t = '0;
        for (int s = 0; s < NSESS; s++) begin
            for (int i = 0; i < MAX_W; i++) begin
                x = vec[pa[s]][i % 5];
                y = vec[pb[s]][i % 5];
                if (x != y)      t[s][2*i +: 2] = WC_FREE;
                else if (x)      t[s][2*i +: 2] = WC_ONE;
                else             t[s][2*i +: 2] = WC_ZERO;
            end
        end
        return t;
    endfunction

    // Feedback masks of maximal-length polynomials (bit k-1 marks tap k).
    function automatic logic [MAX_W-1:0] lfsr_taps(int w);
        case (w)
            5:       return 16'h0014;
            6:       return 16'h0030;
            7:       return 16'h0060;
            8:       return 16'h00B8;
            9:       return 16'h0110;
            10:      return 16'h0240;
            11:      return 16'h0500;
            12:      return 16'h0829;
            13:      return 16'h100D;
            14:      return 16'h2015;
            15:      return 16'h6000;
            default: return 16'hD008;
        endcase
    endfunction

endpackage

// File: rtl/tw_lfsr.sv
module tw_lfsr #(
    parameter int               LW   = 8,
    parameter logic [LW-1:0]    SEED = 8'hA5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          step_i,
    output logic [LW-1:0] state_o
);
    localparam logic [tw_pkg::MAX_W-1:0] TAPS_FULL = tw_pkg::lfsr_taps(LW);
    localparam logic [LW-1:0]            TAPS      = TAPS_FULL[LW-1:0];

    logic [LW-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (step_i) lfsr_d = {lfsr_q[LW-2:0], ^(lfsr_q & TAPS)};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lfsr_q <= SEED;
        else         lfsr_q <= lfsr_d;
    end

    assign state_o = lfsr_q;

    p_lfsr_live_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_q != '0);

endmodule

// File: rtl/tw_acc_cell.sv
module tw_acc_cell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic frc1_i,
    input  logic frc0_i,
    input  logic addend_i,
    input  logic cin_i,
    output logic cout_o,
    output logic a_o,
    output logic b_o
);
    logic a_d, a_q, b_d, b_q, sum_w;
    logic a_set, a_clr, b_set, b_clr;

    // ordinary full adder, untouched by the weighting
    assign sum_w  = a_q ^ b_q ^ cin_i;
    assign cout_o = (a_q & b_q) | (cin_i & (a_q ^ b_q));

    assign a_d = en_i ? sum_w    : a_q;
    assign b_d = en_i ? addend_i : b_q;

    // cross wiring: the line that sets A clears B and the other way round
    assign a_set = frc1_i;
    assign a_clr = ~rst_ni | frc0_i;
    assign b_set = frc0_i;
    assign b_clr = ~rst_ni | frc1_i;

    always_ff @(posedge clk_i or posedge a_clr or posedge a_set) begin
        if (a_clr)      a_q <= 1'b0;
        else if (a_set) a_q <= 1'b1;
        else            a_q <= a_d;
    end

    always_ff @(posedge clk_i or posedge b_clr or posedge b_set) begin
        if (b_clr)      b_q <= 1'b0;
        else if (b_set) b_q <= 1'b1;
        else            b_q <= b_d;
    end

    assign a_o = a_q;
    assign b_o = b_q;

    p_hold_one_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frc1_i |-> (a_q && !b_q));
    p_hold_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frc0_i |-> (!a_q && b_q));
    p_carry_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frc1_i || frc0_i) |-> (cout_o == cin_i));

endmodule

// File: rtl/tw_accum.sv
module tw_accum #(
    parameter int WIDTH = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [WIDTH-1:0] frc1_i,
    input  logic [WIDTH-1:0] frc0_i,
    input  logic [WIDTH-1:0] addend_i,
    output logic [WIDTH-1:0] acc_o
);
    logic [WIDTH:0]   carry_w;
    logic [WIDTH-1:0] b_w;

    assign carry_w[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        tw_acc_cell u_cell (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .en_i     (en_i),
            .frc1_i   (frc1_i[i]),
            .frc0_i   (frc0_i[i]),
            .addend_i (addend_i[i]),
            .cin_i    (carry_w[i]),
            .cout_o   (carry_w[i+1]),
            .a_o      (acc_o[i]),
            .b_o      (b_w[i])
        );
    end

    // with every position held, the zero carry-in must ripple out untouched
    p_chain_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (&(frc1_i | frc0_i)) |-> (carry_w[WIDTH] == 1'b0 && $countones(b_w) == $countones(frc0_i)));

endmodule

// File: rtl/tw_session_ctrl.sv
module tw_session_ctrl #(
    parameter int            WIDTH            = 5,
    parameter int            PATS_PER_SESSION = 8,
    parameter tw_pkg::wtab_t WTAB             = tw_pkg::default_wtab()
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                start_i,
    output logic                                run_o,
    output logic                                valid_o,
    output logic                                done_o,
    output logic [$clog2(tw_pkg::NSESS)-1:0]    sess_o,
    output logic [WIDTH-1:0]                    frc1_o,
    output logic [WIDTH-1:0]                    frc0_o
);
    localparam int SW = $clog2(tw_pkg::NSESS);
    localparam int CW = (PATS_PER_SESSION > 1) ? $clog2(PATS_PER_SESSION) : 1;
    localparam logic [CW-1:0] CNT_LAST  = CW'(PATS_PER_SESSION - 1);
    localparam logic [SW-1:0] SESS_LAST = SW'(tw_pkg::NSESS - 1);

    typedef struct packed {
        logic             run;
        logic             done;
        logic             valid;
        logic [SW-1:0]    sess;
        logic [CW-1:0]    cnt;
        logic [WIDTH-1:0] f1;
        logic [WIDTH-1:0] f0;
    } ctl_t;

    ctl_t c_d, c_q;

    function automatic logic [2*WIDTH-1:0] lines_for(logic [SW-1:0] s);
        logic [WIDTH-1:0] one, zero;
        tw_pkg::wcode_e   code;
        for (int i = 0; i < WIDTH; i++) begin
            code    = tw_pkg::wcode_e'(WTAB[s][2*i +: 2]);
            one[i]  = (code == tw_pkg::WC_ONE);
            zero[i] = (code == tw_pkg::WC_ZERO);
        end
        return {one, zero};
    endfunction

    always_comb begin
        c_d       = c_q;
        c_d.valid = c_q.run;
        if (!c_q.run) begin
            if (start_i) begin
                c_d.run           = 1'b1;
                c_d.done          = 1'b0;
                c_d.sess          = '0;
                c_d.cnt           = '0;
                {c_d.f1, c_d.f0}  = lines_for('0);
            end
        end else if (c_q.cnt == CNT_LAST) begin
            c_d.cnt = '0;
            if (c_q.sess == SESS_LAST) begin
                c_d.run  = 1'b0;
                c_d.done = 1'b1;
            end else begin
                c_d.sess          = c_q.sess + 1'b1;
                {c_d.f1, c_d.f0}  = lines_for(c_q.sess + 1'b1);
            end
        end else begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign run_o   = c_q.run;
    assign valid_o = c_q.valid;
    assign done_o  = c_q.done;
    assign sess_o  = c_q.sess;
    assign frc1_o  = c_q.f1;
    assign frc0_o  = c_q.f0;

    p_sess_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.run && $past(c_q.run) && c_q.sess != $past(c_q.sess))
            |-> (c_q.sess == $past(c_q.sess) + 1'b1 && c_q.cnt == '0));
    p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.run && c_q.cnt != CNT_LAST && start_i) |=> (c_q.run && c_q.sess == $past(c_q.sess)));

endmodule

// File: rtl/tw_pattern_gen.sv
module tw_pattern_gen #(
    parameter int            WIDTH            = 5,
    parameter int            PATS_PER_SESSION = 8,
    parameter int            LFSR_W           = 8,
    parameter logic [LFSR_W-1:0] SEED         = 8'hA5,
    parameter tw_pkg::wtab_t WTAB             = tw_pkg::default_wtab()
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output logic [WIDTH-1:0] pattern_o,
    output logic             pat_valid_o,
    output logic             done_o
);
    localparam int SW = $clog2(tw_pkg::NSESS);

    logic              run_w;
    logic [SW-1:0]     sess_w;
    logic [WIDTH-1:0]  frc1_w, frc0_w;
    logic [LFSR_W-1:0] lfsr_w;

    tw_session_ctrl #(
        .WIDTH            (WIDTH),
        .PATS_PER_SESSION (PATS_PER_SESSION),
        .WTAB             (WTAB)
    ) u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .run_o   (run_w),
        .valid_o (pat_valid_o),
        .done_o  (done_o),
        .sess_o  (sess_w),
        .frc1_o  (frc1_w),
        .frc0_o  (frc0_w)
    );

    tw_lfsr #(
        .LW   (LFSR_W),
        .SEED (SEED)
    ) u_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (run_w),
        .state_o (lfsr_w)
    );

    tw_accum #(
        .WIDTH (WIDTH)
    ) u_acc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (run_w),
        .frc1_i   (frc1_w),
        .frc0_i   (frc0_w),
        .addend_i (lfsr_w[WIDTH-1:0]),
        .acc_o    (pattern_o)
    );

    initial begin
        if (LFSR_W < WIDTH || WIDTH > tw_pkg::MAX_W || LFSR_W > tw_pkg::MAX_W)
            $error("tw_pattern_gen: unsupported width parameters");
    end

    p_held_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_w && $past(run_w) && sess_w == $past(sess_w))
            |-> ((pattern_o & (frc1_w | frc0_w)) == ($past(pattern_o) & (frc1_w | frc0_w))));
    p_done_with_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> pat_valid_o);
    p_done_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && $past(done_o)) |-> ($stable(pattern_o) && !pat_valid_o));
    p_seed_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        |lfsr_w);

endmodule

// File: tb/sim_tw_pattern_gen.sv
module sim_tw_pattern_gen;
    localparam int              W    = 5;
    localparam int              N    = 8;
    localparam int              LW   = 8;
    localparam logic [LW-1:0]   SEED = 8'hA5;
    localparam int              S    = 4;
    // sessions 3..0: mixed codes, one held-0, held-1 with illegal codes, all illegal
    localparam tw_pkg::wtab_t ALT_TAB = {32'h0000_0036, 32'h0000_0200, 32'h0000_03FD, 32'h0000_03FF};

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   start;
    logic [W-1:0] pat   [2];
    logic         valid [2];
    logic         done  [2];

    int tests = 0;
    int fails = 0;

    tw_pkg::wtab_t tab [2];
    logic [W-1:0]  mA [2];
    logic [W-1:0]  mB [2];
    logic [LW-1:0] mL [2];

    always #10 clk = ~clk;

    tw_pattern_gen #(.WIDTH(W), .PATS_PER_SESSION(N), .LFSR_W(LW), .SEED(SEED)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start[0]),
        .pattern_o(pat[0]), .pat_valid_o(valid[0]), .done_o(done[0]));

    tw_pattern_gen #(.WIDTH(W), .PATS_PER_SESSION(N), .LFSR_W(LW), .SEED(SEED), .WTAB(ALT_TAB)) u1 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start[1]),
        .pattern_o(pat[1]), .pat_valid_o(valid[1]), .done_o(done[1]));

    // R7: intersect vector pairs, equal bits -> fixed weight, differing -> free
    function automatic tw_pkg::wtab_t ref_table();
        logic [4:0] v [4];
        int pa [4];
        int pb [4];
        tw_pkg::wtab_t t;
        v[0] = 5'b00101; v[1] = 5'b01010; v[2] = 5'b10010; v[3] = 5'b11111;
        pa[0] = 0; pb[0] = 1; pa[1] = 1; pb[1] = 2;
        pa[2] = 2; pb[2] = 3; pa[3] = 0; pb[3] = 3;
        t = '0;
        for (int s = 0; s < S; s++)
            for (int i = 0; i < W; i++)
                if (v[pa[s]][i] != v[pb[s]][i]) t[s][2*i +: 2] = 2'b00;
                else if (v[pa[s]][i])           t[s][2*i +: 2] = 2'b01;
                else                            t[s][2*i +: 2] = 2'b10;
        return t;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply_force(input int inst, input int s);
        for (int i = 0; i < W; i++) begin
            if (tab[inst][s][2*i +: 2] == 2'b01) begin
                mA[inst][i] = 1'b1; mB[inst][i] = 1'b0;
            end else if (tab[inst][s][2*i +: 2] == 2'b10) begin
                mA[inst][i] = 1'b0; mB[inst][i] = 1'b1;
            end
        end
    endtask

    task automatic model_step(input int inst, input int s);
        logic [W-1:0] sum;
        logic [1:0]   c;
        sum = mA[inst] + mB[inst];
        for (int i = 0; i < W; i++) begin
            c = tab[inst][s][2*i +: 2];
            if (c != 2'b01 && c != 2'b10) begin
                mA[inst][i] = sum[i];
                mB[inst][i] = mL[inst][i];
            end
        end
        // R4: 8-bit polynomial, taps at bits 7,5,4,3
        mL[inst] = {mL[inst][LW-2:0], mL[inst][7] ^ mL[inst][5] ^ mL[inst][4] ^ mL[inst][3]};
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        start = 2'b00;
        repeat (3) @(negedge clk);
        for (int u = 0; u < 2; u++) begin
            check("R1 pattern in reset", 32'(pat[u]), 32'h0);
            check("R1 valid in reset", 32'(valid[u]), 32'h0);
            check("R1 done in reset", 32'(done[u]), 32'h0);
            mA[u] = '0; mB[u] = '0; mL[u] = SEED;
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pattern after reset", 32'(pat[0]), 32'h0);
    endtask

    task automatic t_run(input int inst, input bit midstart, input string tag);
        int s = 0;
        @(negedge clk);
        start[inst] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start[inst] = 1'b0;
        apply_force(inst, 0);
        check({tag, " R5 no strobe on start cycle"}, 32'(valid[inst]), 32'h0);
        check({tag, " R9 done cleared by start"}, 32'(done[inst]), 32'h0);
        check({tag, " R6 session 0 forcing"}, 32'(pat[inst]), 32'(mA[inst]));
        for (int k = 1; k <= N * S; k++) begin
            if (midstart && k == 10) start[inst] = 1'b1;
            @(posedge clk);
            model_step(inst, s);
            if (k % N == 0 && k < N * S) begin
                s++;
                apply_force(inst, s);
            end
            @(negedge clk);
            start[inst] = 1'b0;
            check({tag, " R3 R4 R10 pattern"}, 32'(pat[inst]), 32'(mA[inst]));
            check({tag, " R5 strobe after update"}, 32'(valid[inst]), 32'h1);
            check({tag, " R6 R8 done timing"}, 32'(done[inst]), 32'(k == N * S));
        end
    endtask

    task automatic t_idle(input int inst);
        repeat (4) begin
            @(negedge clk);
            check("R8 no strobe while done", 32'(valid[inst]), 32'h0);
            check("R8 done held", 32'(done[inst]), 32'h1);
            check("R8 pattern frozen", 32'(pat[inst]), 32'(mA[inst]));
        end
    endtask

    initial begin
        tab[0] = ref_table();
        tab[1] = ALT_TAB;
        check("R7 default assignments", 32'(tab[0][0][9:0]), 32'h200);
        t_reset();
        t_run(0, 1'b0, "R7 default run");
        t_idle(0);
        t_run(0, 1'b1, "R9 restart with start mid-run");
        t_idle(0);
        t_run(1, 1'b0, "R2 illegal codes free");
        t_idle(1);
        check("R2 idle instance untouched", 32'(pat[0]), 32'(mA[0]));
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule